// File: doc/BRIEF.md
# Gated Timeslot Receive Byte FIFO

This block collects the serial bits that belong to its assigned TDM timeslots and packs them, MSB first, into bytes. Each completed byte goes into a small receive FIFO for its channel. It has one channel per timeslot, two by default. Each channel shares one serial input and has its own timeslot strobe, its own capture state and its own FIFO. A processor pops bytes from any channel through one read port. Each channel reports a level flag that is high while its FIFO holds half its depth or fewer bytes.

Capture for a channel begins when software writes the activate bit for it. If the gate bit is written in the same activating write, the channel drops every bit until the first zero. That zero is taken as the MSB of the first byte, and the gate bit then clears itself. Once the FIFO is full, each new byte replaces only the newest entry.

The FIFO is a shift-up register file: a read takes location 0 and moves every other entry one place toward it. When a read leaves the FIFO empty, the activate bit drops on its own. Software then restarts capture with a new activating write, with or without the gate bit.

Top module: `tslot_rx_fifo`

## Requirements
- R1: After a synchronous reset, every FIFO is empty, all activate and gate status bits are 0, every level flag is 1, `rd_valid` is 0 and `rd_data` is 0.
- R2: While a channel is inactive, bits in its timeslot are discarded and its FIFO never grows.
- R3: Once a channel is active with the gate clear, its timeslot bits are packed MSB first. The byte enters the FIFO at the clock edge that samples the eighth bit.
- R4: With the gate bit set, 1 bits in the timeslot are ignored. The first 0 bit is the MSB of the first stored byte.
- R5: The gate status bit falls at the clock edge that samples the first 0 bit in the channel's timeslot, and the channel stays active.
- R6: The gate value is taken only by a write with `ctl_act`=1 to an inactive channel. Such a write to an active channel changes neither activate nor gate.
- R7: A bit strobed for one channel reaches only that channel's FIFO.
- R8: A full FIFO keeps accepting bytes, and each new byte overwrites only the newest location.
- R9: A read of a non-empty channel returns its oldest byte on `rd_data` with `rd_valid`=1 one cycle later, and the remaining entries move up. A read of an empty channel gives `rd_valid`=0 and leaves `rd_data` unchanged.
- R10: `level_half[c]` is 1 exactly when channel c holds DEPTH/2 bytes or fewer (2 of 4 by default).
- R11: A read that empties a FIFO clears that channel's activate bit, and so does a write with `ctl_act`=0. A cleared channel restarts byte alignment when it is activated again.
- R12: A read and a byte completion on one channel in the same cycle both take effect: no byte is lost, and a full FIFO stays full with the new byte last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Serial receive data, shared by all channels |
| slot_en | input | NCH | Bit c high: `rx_bit` this cycle belongs to channel c's timeslot |
| ctl_wr | input | 1 | Control write strobe |
| ctl_ch | input | CHW | Channel addressed by the control write |
| ctl_act | input | 1 | Activate value written (1 start, 0 stop) |
| ctl_gate | input | 1 | Gate value, taken only on activation |
| rd_en | input | 1 | Pop request |
| rd_ch | input | CHW | Channel to pop |
| rd_data | output | DW | Last popped byte (registered) |
| rd_valid | output | 1 | Pulses 1 for one cycle after a pop that returned data |
| level_half | output | NCH | Per-channel flag: fill at or below half depth |
| act_q | output | NCH | Per-channel activate status |
| gate_q | output | NCH | Per-channel gate status |

## Verification
A processor read and the completion of a received byte can fall on the same channel in the same clock cycle. This matters most when the FIFO is full, because the pop moves entries up while the overwrite rule targets the newest location. The bench fills a channel to capacity and issues the read in the exact cycle that carries the eighth bit of the next byte. Random traffic also produces the same collision at other fill levels. A reference model that applies the pop first and then the push judges both: every following read must return the four expected bytes in order, and the activate bit must stay set.

// File: rtl/tsrx_pkg.sv
package tsrx_pkg;

  // Width of an occupancy counter able to hold 0..depth.
  function automatic int cnt_bits(input int depth);
    return $clog2(depth + 1);
  endfunction

  // Width of a channel selector (at least one bit).
  function automatic int sel_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Capture control state of one channel.
  typedef struct packed {
    logic act;
    logic gate;
  } chan_ctl_t;

endpackage

// File: rtl/tsrx_deser.sv
// Per-channel bit gate and byte packer, MSB first.
module tsrx_deser
  import tsrx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_in,
  input  logic          slot_hit,
  input  logic          start,
  input  logic          stop,
  input  logic          gate_req,
  output logic          byte_vld,
  output logic [DW-1:0] byte_out,
  output chan_ctl_t     status
);

  localparam int             BCW  = $clog2(DW);
  localparam logic [BCW-1:0] LAST = BCW'(DW - 1);

  logic           active;
  logic           gating;
  logic           take;
  logic [DW-2:0]  sh;
  logic [BCW-1:0] bcnt;

  // A bit counts unless the gate is open and the bit is a one.
  assign take     = active && slot_hit && !(gating && bit_in);
  assign byte_vld = take && (bcnt == LAST);
  assign byte_out = {sh, bit_in};

  assign status.act  = active;
  assign status.gate = gating;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      gating <= 1'b0;
      sh     <= '0;
      bcnt   <= '0;
    end else if (stop) begin
      active <= 1'b0;
      gating <= 1'b0;
      bcnt   <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      gating <= gate_req;
      bcnt   <= '0;
    end else if (take) begin
      gating <= 1'b0;
      sh     <= {sh[DW-3:0], bit_in};
      bcnt   <= byte_vld ? '0 : bcnt + 1'b1;
    end
  end

endmodule

// File: rtl/tsrx_shfifo.sv
// Shift-up receive FIFO: reads come from location 0, a full FIFO
// overwrites its newest location.
module tsrx_shfifo
  import tsrx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int CW   = cnt_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop_req,
  output logic [DW-1:0] head,
  output logic [CW-1:0] fill,
  output logic          half,
  output logic          drained
);

  localparam int            IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL  = CW'(DEPTH);
  localparam logic [CW-1:0] HALFV = CW'(DEPTH / 2);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic [DW-1:0] mem [DEPTH];
  logic          pop;
  logic [CW-1:0] cnt_nxt;
  logic [IW-1:0] widx;

  assign pop     = pop_req && (fill != '0);
  assign drained = pop && !push && (fill == ONE);
  assign head    = mem[0];

  always_comb begin
    if (pop && !push)                      cnt_nxt = fill - ONE;
    else if (push && !pop && fill != FULL) cnt_nxt = fill + ONE;
    else                                   cnt_nxt = fill;
  end

  // Write slot: after a shift the slot is fill-1, when full it is the
  // newest location, otherwise the first free one.
  always_comb begin
    if (pop)                widx = IW'(fill - ONE);
    else if (fill == FULL)  widx = IW'(DEPTH - 1);
    else                    widx = IW'(fill);
  end

  always_ff @(posedge clk) begin
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) mem[i] <= mem[i+1];
    end
    if (push) mem[widx] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill <= '0;
      half <= 1'b1;
    end else begin
      fill <= cnt_nxt;
      half <= (cnt_nxt <= HALFV);
    end
  end

endmodule

// File: rtl/tslot_rx_fifo.sv
// Multi-channel gated timeslot receive FIFO.
module tslot_rx_fifo
  import tsrx_pkg::*;
#(
  parameter int  NCH   = 2,
  parameter int  DW    = 8,
  parameter int  DEPTH = 4,
  localparam int CHW   = sel_bits(NCH),
  localparam int CW    = cnt_bits(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rx_bit,
  input  logic [NCH-1:0] slot_en,
  input  logic           ctl_wr,
  input  logic [CHW-1:0] ctl_ch,
  input  logic           ctl_act,
  input  logic           ctl_gate,
  input  logic           rd_en,
  input  logic [CHW-1:0] rd_ch,
  output logic [DW-1:0]  rd_data,
  output logic           rd_valid,
  output logic [NCH-1:0] level_half,
  output logic [NCH-1:0] act_q,
  output logic [NCH-1:0] gate_q
);

  logic [NCH-1:0][DW-1:0] head_a;
  logic [NCH-1:0][CW-1:0] fill;
  logic [NCH-1:0]         drained;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic          wr_hit;
    logic          start;
    logic          stop;
    logic          pop_req;
    logic          byte_vld;
    logic [DW-1:0] byte_val;
    chan_ctl_t     st;

    assign wr_hit  = ctl_wr && (ctl_ch == CHW'(ch));
    assign start   = wr_hit && ctl_act;
    assign stop    = (wr_hit && !ctl_act) || drained[ch];
    assign pop_req = rd_en && (rd_ch == CHW'(ch));

    tsrx_deser #(.DW(DW)) u_deser (
      .clk      (clk),
      .rst      (rst),
      .bit_in   (rx_bit),
      .slot_hit (slot_en[ch]),
      .start    (start),
      .stop     (stop),
      .gate_req (ctl_gate),
      .byte_vld (byte_vld),
      .byte_out (byte_val),
      .status   (st)
    );

    tsrx_shfifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .push    (byte_vld),
      .din     (byte_val),
      .pop_req (pop_req),
      .head    (head_a[ch]),
      .fill    (fill[ch]),
      .half    (level_half[ch]),
      .drained (drained[ch])
    );

    assign act_q[ch]  = st.act;
    assign gate_q[ch] = st.gate;
  end

  logic [DW-1:0] sel_head;
  logic          sel_any;

  always_comb begin
    sel_head = '0;
    sel_any  = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (rd_ch == CHW'(c)) begin
        sel_head = head_a[c];
        sel_any  = (fill[c] != '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en && sel_any;
      if (rd_en && sel_any) rd_data <= sel_head;
    end
  end

endmodule

// File: rtl/tsrx_chk.sv
// Property checker for tslot_rx_fifo, attached by bind.
module tsrx_chk #(
  parameter int NCH   = 2,
  parameter int DEPTH = 4,
  parameter int CHW   = 1,
  parameter int CW    = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   rx_bit,
  input logic [NCH-1:0]         slot_en,
  input logic                   rd_en,
  input logic [CHW-1:0]         rd_ch,
  input logic                   rd_valid,
  input logic [NCH-1:0]         level_half,
  input logic [NCH-1:0]         act_q,
  input logic [NCH-1:0]         gate_q,
  input logic [NCH-1:0][CW-1:0] fill
);

  localparam logic [CW-1:0] FULL  = CW'(DEPTH);
  localparam logic [CW-1:0] HALFV = CW'(DEPTH / 2);

  // R1: reset leaves every channel idle and no read result pending
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (act_q == '0 && gate_q == '0 && !rd_valid));

  // R9: read data only ever follows a read request
  a_r9_valid_needs_read: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R8: occupancy never exceeds the depth
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
      fill[c] <= FULL);

    // R10: level flag agrees with the occupancy
    a_r10_level_flag: assert property (@(posedge clk) disable iff (rst)
      level_half[c] == (fill[c] <= HALFV));

    // R2: an inactive channel does not grow
    a_r2_idle_no_growth: assert property (@(posedge clk) disable iff (rst)
      !act_q[c] |=> fill[c] <= $past(fill[c]));

    // R4: a one bit seen while gated stores nothing
    a_r4_gate_drops_ones: assert property (@(posedge clk) disable iff (rst)
      (gate_q[c] && slot_en[c] && rx_bit && !(rd_en && rd_ch == CHW'(c)))
      |=> $stable(fill[c]));

    // R5: the gate opens only on a zero in the channel's own timeslot
    a_r5_gate_on_zero: assert property (@(posedge clk) disable iff (rst)
      ($fell(gate_q[c]) && act_q[c]) |-> $past(slot_en[c] && !rx_bit));

    // R11: emptying the FIFO leaves the channel inactive
    a_r11_drain_stops: assert property (@(posedge clk) disable iff (rst)
      ($past(fill[c]) != '0 && fill[c] == '0) |-> !act_q[c]);
  end

endmodule

bind tslot_rx_fifo tsrx_chk #(
  .NCH(NCH), .DEPTH(DEPTH), .CHW(CHW), .CW(CW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rx_bit     (rx_bit),
  .slot_en    (slot_en),
  .rd_en      (rd_en),
  .rd_ch      (rd_ch),
  .rd_valid   (rd_valid),
  .level_half (level_half),
  .act_q      (act_q),
  .gate_q     (gate_q),
  .fill       (fill)
);

// File: tb/tslot_rx_fifo_tb.sv
module tslot_rx_fifo_tb;

  localparam int NCH = 2, DW = 8, DEPTH = 4, CHW = 1;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           rx_bit = 1'b0;
  logic [NCH-1:0] slot_en = '0;
  logic           ctl_wr = 1'b0;
  logic [CHW-1:0] ctl_ch = '0;
  logic           ctl_act = 1'b0;
  logic           ctl_gate = 1'b0;
  logic           rd_en = 1'b0;
  logic [CHW-1:0] rd_ch = '0;
  logic [DW-1:0]  rd_data;
  logic           rd_valid;
  logic [NCH-1:0] level_half, act_q, gate_q;

  always #2 clk = ~clk;

  tslot_rx_fifo #(.NCH(NCH), .DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .slot_en(slot_en),
    .ctl_wr(ctl_wr), .ctl_ch(ctl_ch), .ctl_act(ctl_act), .ctl_gate(ctl_gate),
    .rd_en(rd_en), .rd_ch(rd_ch), .rd_data(rd_data), .rd_valid(rd_valid),
    .level_half(level_half), .act_q(act_q), .gate_q(gate_q)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model, written from the requirements.
  logic [7:0] m_mem [NCH][DEPTH];
  int         m_cnt [NCH];
  bit         m_act [NCH];
  bit         m_gate[NCH];
  logic [6:0] m_sh  [NCH];
  int         m_nb  [NCH];
  logic [7:0] m_rd;
  bit         m_rv;

  function automatic void model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_cnt[c] = 0; m_act[c] = 0; m_gate[c] = 0; m_sh[c] = '0; m_nb[c] = 0;
    end
    m_rd = '0; m_rv = 0;
  endfunction

  function automatic void model_step(bit b, bit [1:0] se, bit w, int wc,
                                     bit wa, bit wg, bit r, int rc);
    m_rv = 0;
    for (int c = 0; c < NCH; c++) begin
      bit push = 0, pop, act_old;
      logic [7:0] pb = '0;
      act_old = m_act[c];
      if (m_act[c] && se[c] && !(m_gate[c] && b)) begin
        pb = {m_sh[c], b};
        m_sh[c] = {m_sh[c][5:0], b};
        m_gate[c] = 0;
        if (m_nb[c] == 7) begin push = 1; m_nb[c] = 0; end
        else m_nb[c]++;
      end
      pop = r && (rc == c) && (m_cnt[c] != 0);
      if (pop) begin
        m_rd = m_mem[c][0]; m_rv = 1;
        for (int i = 0; i < DEPTH - 1; i++) m_mem[c][i] = m_mem[c][i+1];
        m_cnt[c]--;
      end
      if (push) begin
        if (m_cnt[c] < DEPTH) begin m_mem[c][m_cnt[c]] = pb; m_cnt[c]++; end
        else m_mem[c][DEPTH-1] = pb;
      end
      if (pop && !push && m_cnt[c] == 0) begin
        m_act[c] = 0; m_gate[c] = 0; m_nb[c] = 0;
      end else if (w && wc == c) begin
        if (!wa) begin m_act[c] = 0; m_gate[c] = 0; m_nb[c] = 0; end
        else if (!act_old) begin m_act[c] = 1; m_gate[c] = wg; m_nb[c] = 0; end
      end
    end
  endfunction

  task automatic cyc(input bit b, input bit [1:0] se, input bit w, input int wc,
                     input bit wa, input bit wg, input bit r, input int rc);
    @(negedge clk);
    rx_bit = b; slot_en = se; ctl_wr = w; ctl_ch = 1'(wc);
    ctl_act = wa; ctl_gate = wg; rd_en = r; rd_ch = 1'(rc);
    model_step(b, se, w, wc, wa, wg, r, rc);
    @(posedge clk);
    #1;
    for (int c = 0; c < NCH; c++) begin
      chk($sformatf("R11 act ch%0d", c), int'(act_q[c]), int'(m_act[c]));
      chk($sformatf("R5 gate ch%0d", c), int'(gate_q[c]), int'(m_gate[c]));
      chk($sformatf("R10 level ch%0d", c), int'(level_half[c]), int'(m_cnt[c] <= DEPTH/2));
    end
    chk("R9 rd_valid", int'(rd_valid), int'(m_rv));
    chk("R9 rd_data", int'(rd_data), int'(m_rd));
  endtask

  task automatic idle(input int n);
    repeat (n) cyc(0, 2'b00, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic start(input int ch, input bit g);
    cyc(0, 2'b00, 1, ch, 1, g, 0, 0);
  endtask
  task automatic halt(input int ch);
    cyc(0, 2'b00, 1, ch, 0, 0, 0, 0);
  endtask
  task automatic pop(input int ch);
    cyc(0, 2'b00, 0, 0, 0, 0, 1, ch);
  endtask
  task automatic send_byte(input int ch, input logic [7:0] v);
    for (int i = 7; i >= 0; i--) cyc(v[i], 2'(1 << ch), 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1b7c_0d3e));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 act", int'(act_q), 0);
    chk("R1 gate", int'(gate_q), 0);
    chk("R1 level", int'(level_half), 3);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 rd_data", int'(rd_data), 0);

    // R2: bits while inactive are dropped
    for (int i = 0; i < 16; i++) cyc(i[0], 2'(1 + (i % 2)), 0, 0, 0, 0, 0, 0);
    pop(0); chk("R2 read after idle bits ch0", int'(rd_valid), 0);
    pop(1); chk("R2 read after idle bits ch1", int'(rd_valid), 0);

    // R3: ungated packing, MSB first, with gaps between bits
    start(0, 0);
    for (int i = 7; i >= 0; i--) begin
      cyc(8'hA5 >> i, 2'b01, 0, 0, 0, 0, 0, 0);
      idle(1);
    end
    pop(0); chk("R3 byte A5", int'(rd_data), 'hA5);
    chk("R11 auto clear after drain", int'(act_q[0]), 0);

    // R4 and R5: gated start on first zero
    start(1, 1);
    chk("R6 gate latched on activation", int'(gate_q[1]), 1);
    repeat (5) cyc(1, 2'b10, 0, 0, 0, 0, 0, 0);
    chk("R4 ones ignored while gated", int'(gate_q[1]), 1);
    cyc(0, 2'b10, 0, 0, 0, 0, 0, 0);
    chk("R5 gate falls on first zero", int'(gate_q[1]), 0);
    chk("R5 channel stays active", int'(act_q[1]), 1);
    for (int i = 6; i >= 0; i--) cyc(8'h3C >> i, 2'b10, 0, 0, 0, 0, 0, 0);
    pop(1); chk("R4 first zero is MSB", int'(rd_data), 'h3C);

    // R6: gate write to an active channel is ignored
    start(0, 0);
    start(0, 1);
    chk("R6 gate unchanged while active", int'(gate_q[0]), 0);
    send_byte(0, 8'hF0);
    pop(0); chk("R6 byte not gated", int'(rd_data), 'hF0);

    // R7: interleaved channels stay apart
    start(0, 0); start(1, 0);
    for (int i = 7; i >= 0; i--) begin
      cyc(8'h12 >> i, 2'b01, 0, 0, 0, 0, 0, 0);
      cyc(8'hEF >> i, 2'b10, 0, 0, 0, 0, 0, 0);
    end
    pop(0); chk("R7 ch0 byte", int'(rd_data), 'h12);
    pop(0); chk("R7 ch0 holds one byte", int'(rd_valid), 0);
    pop(1); chk("R7 ch1 byte", int'(rd_data), 'hEF);

    // R8 and R10: fill, overflow into newest location
    start(0, 0);
    send_byte(0, 8'h11); chk("R10 level at 1", int'(level_half[0]), 1);
    send_byte(0, 8'h22); chk("R10 level at half", int'(level_half[0]), 1);
    send_byte(0, 8'h33); chk("R10 level above half", int'(level_half[0]), 0);
    send_byte(0, 8'h44);
    send_byte(0, 8'h55);
    send_byte(0, 8'h66);
    pop(0); chk("R8 entry 0 kept", int'(rd_data), 'h11);
    pop(0); chk("R8 entry 1 kept", int'(rd_data), 'h22);
    pop(0); chk("R8 entry 2 kept", int'(rd_data), 'h33);
    pop(0); chk("R8 newest overwritten", int'(rd_data), 'h66);
    pop(0); chk("R9 empty read no valid", int'(rd_valid), 0);
    chk("R9 empty read keeps data", int'(rd_data), 'h66);

    // R12: pop in the cycle of the eighth bit while full
    start(0, 0);
    send_byte(0, 8'h81); send_byte(0, 8'h82);
    send_byte(0, 8'h83); send_byte(0, 8'h84);
    for (int i = 7; i >= 1; i--) cyc(8'h85 >> i, 2'b01, 0, 0, 0, 0, 0, 0);
    cyc(1, 2'b01, 0, 0, 0, 0, 1, 0);
    chk("R12 pop returns oldest", int'(rd_data), 'h81);
    chk("R12 still active", int'(act_q[0]), 1);
    pop(0); chk("R12 next 82", int'(rd_data), 'h82);
    pop(0); chk("R12 next 83", int'(rd_data), 'h83);
    pop(0); chk("R12 next 84", int'(rd_data), 'h84);
    pop(0); chk("R12 new byte kept", int'(rd_data), 'h85);

    // R11: explicit stop, then bytes are dropped
    start(1, 0);
    halt(1); chk("R11 stop write clears", int'(act_q[1]), 0);
    send_byte(1, 8'h5A);
    pop(1); chk("R2 stopped channel stores nothing", int'(rd_valid), 0);

    // Random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int  s = $urandom % 3;
      bit  w = ($urandom % 20) == 0;
      bit  r = ($urandom % 5) == 0;
      cyc(1'($urandom), 2'(s), w, int'($urandom % 2), ($urandom % 3) != 0,
          1'($urandom), r, int'($urandom % 2));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule